// File: doc/BRIEF.md
# Misaligned Memory Access Handler

This block sits between a load/store requester and a memory port that is 32 bits wide and addressed by word. The requester gives a byte address, an access size of one, two or four bytes, a read/write flag, write data and a policy code. The handler works out whether the access is naturally aligned. It then issues one or two word transactions, each with per-lane byte enables. For reads, it returns the bytes right-justified and zero-extended. Operation is little-endian.

A misaligned request is handled according to the policy code, which is sampled when the request is accepted. There are three policies. The split policy breaks an access that straddles a word boundary into two word transactions, lower word first, and merges the returned bytes. The round-down policy clears the offending low address bits and makes one aligned access. The trap policy reports a fault and does not touch memory. The memory side uses a request/acknowledge handshake, so each word transaction may take any number of cycles.

Top module: `misalign_access_unit`

## Requirements
- R1: During and right after reset, `reqReady` is 1 and `doneValid`, `doneFault` and `memReq` are 0.
- R2: Size code 0 is one byte, 1 is two bytes, and 2 or 3 is four bytes. An access of n bytes is misaligned when `addr mod n` is not zero, so a one-byte access is never misaligned.
- R3: An aligned access makes exactly one transaction under every policy. Its word address is `addr[AddrW-1:2]` and byte lane k is enabled for bytes `addr[1:0]` to `addr[1:0]+n-1`. Write data byte i goes to lane `addr[1:0]+i`. Read byte i comes from that lane and lands at result byte i, and the upper result bytes are zero.
- R4: Under the split policy (code 0, and also code 3), a misaligned access that stays inside one word makes a single transaction with the lanes of R3.
- R5: Under the split policy, an access whose bytes cross a word boundary makes two transactions. The lower word (`addr>>2`) goes first with the lanes from the offset up to lane 3. The next word (+1, wrapping at the top) follows with lanes 0 upward for the remaining bytes. The write data is split to match.
- R6: A split read returns the bytes of both words merged in address order, right-justified and zero-extended. `doneValid` is raised only after the second transaction is acknowledged.
- R7: Under the round-down policy (code 1), a misaligned access uses the address with its low log2(n) bits cleared and makes one transaction.
- R8: Under the trap policy (code 2), a misaligned request makes no memory transaction. It raises `doneValid` together with `doneFault` in the second cycle after acceptance, and the read result is 0. Any request that completes without a fault has `doneFault` at 0.
- R9: `memReq` stays high until the clock edge on which `memAck` is seen. While it waits, `memAddr`, `memBe`, `memWdata` and `memWrite` do not change. Any acknowledge latency is accepted.
- R10: A request is accepted only on an edge where `reqReady` is 1, and `reqReady` is 0 from acceptance until completion. Requests offered while busy are ignored. Changes to the request inputs after acceptance, including the policy, have no effect.
- R11: `doneValid` is a single-cycle pulse in the cycle after the edge that takes the final acknowledge. `doneRdata` is valid in that cycle and is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Handler idle; request taken on this edge if valid |
| reqAddr | input | AddrW | Byte address |
| reqSize | input | 2 | Size code (0 byte, 1 half, 2/3 word) |
| reqWrite | input | 1 | 1 for store, 0 for load |
| reqWdata | input | 32 | Store data, right-justified |
| reqMode | input | 2 | Misalignment policy (0/3 split, 1 round-down, 2 trap) |
| doneValid | output | 1 | Completion pulse |
| doneFault | output | 1 | Completion was an alignment fault |
| doneRdata | output | 32 | Load result, right-justified, zero-extended |
| memReq | output | 1 | Word transaction request |
| memWrite | output | 1 | Transaction is a write |
| memAddr | output | AddrW-2 | Word address |
| memBe | output | 4 | Byte-lane enables |
| memWdata | output | 32 | Lane-positioned write data |
| memAck | input | 1 | Transaction accepted/completed on this edge |
| memRdata | input | 32 | Read word, valid with memAck |

## Verification
A non-faulting result is due one cycle after the edge that takes the last acknowledge. The bench's memory model records the cycle in which it raised that acknowledge and expects `doneValid` exactly one cycle later. A trap fault is due two cycles after the accepting edge, and that exact count is checked. Outputs are sampled on the falling edge, and the memory model checks on each falling edge that a waiting transaction holds still. The pulse width is confirmed at the falling edge after completion, and junk requests with a changed policy are driven during every busy window.

// File: rtl/mau_pkg.sv
package mau_pkg;
  localparam int WordBytes = 4;
  localparam int WordW     = 8 * WordBytes;
  localparam int LaneW     = $clog2(WordBytes);

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_ROUND = 2'd1,
    MODE_TRAP  = 2'd2
  } missPolicy_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic latchLo;
    logic latchHi;
    logic selHigh;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic fault;
    logic twoWords;
  } dpStat_t;
endpackage

// File: rtl/mau_datapath.sv
module mau_datapath
  import mau_pkg::*;
#(
  parameter int AddrW = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctrl,
  input  logic [AddrW-1:0]         reqAddr,
  input  logic [1:0]               reqSize,
  input  logic                     reqWrite,
  input  logic [WordW-1:0]         reqWdata,
  input  logic [1:0]               reqMode,
  input  logic [WordW-1:0]         memRdata,
  output dpStat_t                  stat,
  output logic [AddrW-LaneW-1:0]   memAddr,
  output logic [WordBytes-1:0]     memBe,
  output logic [WordW-1:0]         memWdata,
  output logic                     memWrite,
  output logic [WordW-1:0]         resultData
);
  localparam int WordAddrW = AddrW - LaneW;
  localparam int SpanLanes = 2 * WordBytes;
  localparam int CntW      = LaneW + 1;

  logic [AddrW-1:0] aReg;
  logic [1:0]       sizeReg;
  logic             writeReg;
  logic [WordW-1:0] wdReg;
  logic [1:0]       modeReg;
  logic [WordW-1:0] rdLo, rdHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      sizeReg  <= '0;
      writeReg <= 1'b0;
      wdReg    <= '0;
      modeReg  <= '0;
      rdLo     <= '0;
      rdHi     <= '0;
    end else begin
      if (ctrl.capture) begin
        aReg     <= reqAddr;
        sizeReg  <= reqSize;
        writeReg <= reqWrite;
        wdReg    <= reqWdata;
        modeReg  <= reqMode;
        rdLo     <= '0;
        rdHi     <= '0;
      end
      if (ctrl.latchLo) rdLo <= memRdata;
      if (ctrl.latchHi) rdHi <= memRdata;
    end
  end

  // access classification
  logic [CntW-1:0]  nBytes;
  logic [LaneW-1:0] lowMask;
  logic             misaligned;
  logic             roundSel;
  logic [AddrW-1:0] effAddr;
  logic [LaneW-1:0] off;

  always_comb begin
    case (sizeReg)
      2'd0:    nBytes = CntW'(1);
      2'd1:    nBytes = CntW'(2);
      default: nBytes = CntW'(WordBytes);
    endcase
    lowMask    = LaneW'(nBytes - CntW'(1));
    misaligned = |(aReg[LaneW-1:0] & lowMask);
    roundSel   = (modeReg == MODE_ROUND) && misaligned;
    effAddr    = roundSel ? (aReg & ~AddrW'(lowMask)) : aReg;
    off        = effAddr[LaneW-1:0];
  end

  assign stat.fault = (modeReg == MODE_TRAP) && misaligned;

  // lanes touched across a two-word window
  logic [SpanLanes-1:0] span;
  logic [WordBytes-1:0] keepLane;

  for (genvar j = 0; j < SpanLanes; j++) begin : g_span
    assign span[j] = (j >= int'(off)) && (j < int'(off) + int'(nBytes));
  end

  assign stat.twoWords = |span[SpanLanes-1:WordBytes];

  logic [2*WordW-1:0] wideWd;
  logic [WordW-1:0]   alignedRd;

  assign wideWd    = {{WordW{1'b0}}, wdReg} << {off, 3'b000};
  assign alignedRd = WordW'({rdHi, rdLo} >> {off, 3'b000});

  for (genvar j = 0; j < WordBytes; j++) begin : g_result
    assign keepLane[j] = (j < int'(nBytes)) && !writeReg && !stat.fault;
    assign resultData[8*j +: 8] = keepLane[j] ? alignedRd[8*j +: 8] : 8'h00;
  end

  assign memAddr  = effAddr[AddrW-1:LaneW] + WordAddrW'(ctrl.selHigh);
  assign memBe    = ctrl.selHigh ? span[SpanLanes-1:WordBytes] : span[WordBytes-1:0];
  assign memWdata = ctrl.selHigh ? wideWd[2*WordW-1:WordW] : wideWd[WordW-1:0];
  assign memWrite = writeReg;

  // R5: the upper word is addressed only for straddling accesses
  p_high_only_when_split_r5 : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.selHigh |-> stat.twoWords);

  // R8: no read data is taken for a faulting request
  p_no_latch_on_fault_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.latchLo || ctrl.latchHi) |-> !stat.fault);
endmodule

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memAck,
  input  dpStat_t stat,
  output logic    reqReady,
  output logic    memReq,
  output logic    doneValid,
  output dpCtrl_t ctrl
);
  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    doneValid = 1'b0;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.capture = 1'b1;
          stateNext    = ST_LOW;
        end
      end
      ST_LOW: begin
        if (stat.fault) begin
          stateNext = ST_DONE;
        end else begin
          memReq = 1'b1;
          if (memAck) begin
            ctrl.latchLo = 1'b1;
            stateNext    = stat.twoWords ? ST_HIGH : ST_DONE;
          end
        end
      end
      ST_HIGH: begin
        memReq       = 1'b1;
        ctrl.selHigh = 1'b1;
        if (memAck) begin
          ctrl.latchHi = 1'b1;
          stateNext    = ST_DONE;
        end
      end
      default: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

  // R9: a pending transaction is not withdrawn
  p_hold_until_ack_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R11: completion is one cycle wide
  p_done_pulse_r11 : assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R10: no new request while memory is being used
  p_busy_not_ready_r10 : assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);
endmodule

// File: rtl/misalign_access_unit.sv
module misalign_access_unit
  import mau_pkg::*;
#(
  parameter int AddrW = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [AddrW-1:0]       reqAddr,
  input  logic [1:0]             reqSize,
  input  logic                   reqWrite,
  input  logic [31:0]            reqWdata,
  input  logic [1:0]             reqMode,
  output logic                   doneValid,
  output logic                   doneFault,
  output logic [31:0]            doneRdata,
  output logic                   memReq,
  output logic                   memWrite,
  output logic [AddrW-3:0]       memAddr,
  output logic [3:0]             memBe,
  output logic [31:0]            memWdata,
  input  logic                   memAck,
  input  logic [31:0]            memRdata
);
  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  mau_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .memAck    (memAck),
    .stat      (dpStat),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .doneValid (doneValid),
    .ctrl      (dpCtrl)
  );

  mau_datapath #(.AddrW(AddrW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (dpCtrl),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .reqMode    (reqMode),
    .memRdata   (memRdata),
    .stat       (dpStat),
    .memAddr    (memAddr),
    .memBe      (memBe),
    .memWdata   (memWdata),
    .memWrite   (memWrite),
    .resultData (doneRdata)
  );

  assign doneFault = doneValid && dpStat.fault;

  // R9: transaction fields hold while waiting for the acknowledge
  p_fields_stable_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memBe) &&
                             $stable(memWdata) && $stable(memWrite)));

  // R8: a faulting request never reaches memory
  p_no_access_on_fault_r8 : assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !dpStat.fault);

  // R3: every issued transaction enables at least one lane
  p_lanes_present_r3 : assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBe != 4'b0000));
endmodule

// File: tb/misalign_access_unit_bench.sv
`timescale 1ns/100ps
module misalign_access_unit_bench;
  localparam int AW    = 12;
  localparam int WORDS = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [1:0] reqMode = '0;
  logic doneValid, doneFault;
  logic [31:0] doneRdata;
  logic memReq, memWrite;
  logic [AW-3:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  misalign_access_unit #(.AddrW(AW)) u_misalign_access_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqMode(reqMode), .doneValid(doneValid),
    .doneFault(doneFault), .doneRdata(doneRdata), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model with variable acknowledge latency
  logic [31:0] mem [0:WORDS-1];
  int waitCnt = 0;
  int fixedDelay = -1;
  bit holdValid = 0;
  logic [AW-3:0] heldAddr;
  logic [3:0] heldBe;
  logic [31:0] heldWd;
  logic heldWr;
  int holdErr = 0;
  int waitsSeen = 0;
  int txN = 0;
  logic [AW-3:0] txA [0:3];
  logic [3:0] txBe [0:3];
  int lastAckCyc = 0;

  function automatic int pickDelay();
    return (fixedDelay >= 0) ? fixedDelay : int'($urandom_range(0, 3));
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0;
      waitCnt = 0;
      holdValid = 0;
    end else if (memAck) begin
      memAck = 1'b0;
      waitCnt = pickDelay();
    end else if (memReq) begin
      if (holdValid && (memAddr !== heldAddr || memBe !== heldBe ||
                        memWdata !== heldWd || memWrite !== heldWr))
        holdErr++;
      if (waitCnt == 0) begin
        memAck = 1'b1;
        memRdata = mem[memAddr];
        if (memWrite)
          for (int k = 0; k < 4; k++)
            if (memBe[k]) mem[memAddr][8*k +: 8] = memWdata[8*k +: 8];
        if (txN < 4) begin
          txA[txN] = memAddr;
          txBe[txN] = memBe;
        end
        txN++;
        lastAckCyc = cyc;
        holdValid = 0;
      end else begin
        waitsSeen++;
        holdValid = 1;
        heldAddr = memAddr; heldBe = memBe; heldWd = memWdata; heldWr = memWrite;
        waitCnt--;
      end
    end
  end

  task automatic doOp(input logic [AW-1:0] addr, input logic [1:0] size, input bit wr,
                      input logic [31:0] wd, input logic [1:0] mode, input string tag);
    int n, eff, expTx, c0, doneCyc;
    bit mis, flt, rnd, seen;
    logic [AW-3:0] wA [0:1];
    logic [3:0] wBe [0:1];
    logic [31:0] expRd, gotRd;
    logic [31:0] expMem [0:1];
    logic gotFault;
    n = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    mis = (int'(addr) % n) != 0;
    flt = (mode == 2'd2) && mis;
    rnd = (mode == 2'd1) && mis;
    eff = rnd ? int'(addr) - (int'(addr) % n) : int'(addr);
    wA[0] = (AW-2)'((eff / 4) % WORDS);
    wA[1] = (AW-2)'(((eff / 4) + 1) % WORDS);
    wBe[0] = '0; wBe[1] = '0;
    expRd = '0;
    expTx = flt ? 0 : 1;
    expMem[0] = mem[wA[0]];
    expMem[1] = mem[wA[1]];
    if (!flt)
      for (int i = 0; i < n; i++) begin
        int b, w, l;
        b = (eff % 4) + i; w = b / 4; l = b % 4;
        wBe[w][l] = 1'b1;
        if (w == 1) expTx = 2;
        if (wr) expMem[w][8*l +: 8] = wd[8*i +: 8];
        else    expRd[8*i +: 8] = mem[wA[w]][8*l +: 8];
      end

    @(negedge clk);
    check(reqReady === 1'b1, "R10", "ready when idle", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqAddr = addr; reqSize = size; reqWrite = wr;
    reqWdata = wd; reqMode = mode;
    txN = 0;
    c0 = cyc;
    @(negedge clk);
    // busy: offer junk requests and a changed policy, all to be ignored
    reqAddr = AW'($urandom); reqSize = 2'($urandom); reqWrite = 1'($urandom);
    reqWdata = $urandom; reqMode = 2'($urandom);
    seen = 0; doneCyc = 0; gotRd = '0; gotFault = 1'b0;
    for (int k = 0; k < 200 && !seen; k++) begin
      if (doneValid === 1'b1) begin
        seen = 1; doneCyc = cyc; gotRd = doneRdata; gotFault = doneFault;
        reqValid = 1'b0;
      end else @(negedge clk);
    end
    reqValid = 1'b0;
    check(seen, tag, "completion seen (R11)", 32'(seen), 32'd1);
    check(gotFault === flt, tag, "fault flag (R8)", 32'(gotFault), 32'(flt));
    check(gotRd === expRd, tag, "read result (R6)", gotRd, expRd);
    check(txN == expTx, tag, "transaction count (R5)", 32'(txN), 32'(expTx));
    for (int t = 0; t < expTx && t < txN; t++) begin
      check(txA[t] === wA[t], tag, "word address", 32'(txA[t]), 32'(wA[t]));
      check(txBe[t] === wBe[t], tag, "byte enables", 32'(txBe[t]), 32'(wBe[t]));
    end
    if (flt) check(doneCyc == c0 + 2, "R8", "fault latency", 32'(doneCyc - c0), 32'd2);
    else     check(doneCyc == lastAckCyc + 1, "R11", "done after final ack",
                   32'(doneCyc - lastAckCyc), 32'd1);
    check(mem[wA[0]] === expMem[0], tag, "memory word low", mem[wA[0]], expMem[0]);
    check(mem[wA[1]] === expMem[1], tag, "memory word high", mem[wA[1]], expMem[1]);
    @(negedge clk);
    check(doneValid === 1'b0, "R11", "done is one cycle", 32'(doneValid), 32'd0);
    check(memReq === 1'b0, "R10", "no access from ignored requests", 32'(memReq), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < WORDS; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    check(reqReady === 1'b1, "R1", "ready in reset", 32'(reqReady), 32'd1);
    check(doneValid === 1'b0 && doneFault === 1'b0, "R1", "done in reset",
          {30'd0, doneValid, doneFault}, 32'd0);
    check(memReq === 1'b0, "R1", "memReq in reset", 32'(memReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1 && memReq === 1'b0, "R1", "idle after reset",
          {30'd0, reqReady, memReq}, 32'd2);

    // aligned, every policy
    doOp(12'h010, 2'd2, 0, 32'h0, 2'd0, "R3");
    doOp(12'h020, 2'd2, 1, 32'hDEADBEEF, 2'd1, "R3");
    doOp(12'h024, 2'd1, 0, 32'h0, 2'd2, "R3");
    doOp(12'h02A, 2'd1, 1, 32'h0000CAFE, 2'd2, "R3");
    // size codes and alignment rule
    doOp(12'h031, 2'd0, 0, 32'h0, 2'd2, "R2");
    doOp(12'h033, 2'd0, 1, 32'h000000A5, 2'd2, "R2");
    doOp(12'h036, 2'd3, 0, 32'h0, 2'd2, "R2");
    doOp(12'h034, 2'd3, 0, 32'h0, 2'd2, "R2");
    // split inside one word
    doOp(12'h041, 2'd1, 0, 32'h0, 2'd0, "R4");
    doOp(12'h045, 2'd1, 1, 32'h00001234, 2'd0, "R4");
    // split across words
    doOp(12'h053, 2'd1, 1, 32'h0000ABCD, 2'd0, "R5");
    doOp(12'h053, 2'd1, 0, 32'h0, 2'd0, "R6");
    doOp(12'h061, 2'd2, 0, 32'h0, 2'd0, "R6");
    doOp(12'h062, 2'd2, 0, 32'h0, 2'd0, "R6");
    doOp(12'h067, 2'd2, 1, 32'h11223344, 2'd0, "R5");
    doOp(12'h072, 2'd2, 0, 32'h0, 2'd3, "R5");
    doOp(12'hFFE, 2'd2, 0, 32'h0, 2'd0, "R5");
    // round-down
    doOp(12'h083, 2'd1, 0, 32'h0, 2'd1, "R7");
    doOp(12'h086, 2'd2, 1, 32'h55667788, 2'd1, "R7");
    doOp(12'h08B, 2'd2, 0, 32'h0, 2'd1, "R7");
    // trap
    doOp(12'h091, 2'd1, 0, 32'h0, 2'd2, "R8");
    doOp(12'h097, 2'd2, 1, 32'h99999999, 2'd2, "R8");
    // long waits with requests offered while busy
    fixedDelay = 6;
    doOp(12'h0A5, 2'd2, 0, 32'h0, 2'd0, "R10");
    doOp(12'h0B2, 2'd2, 1, 32'h0BADF00D, 2'd0, "R9");
    fixedDelay = -1;

    for (int r = 0; r < 400; r++)
      doOp(AW'($urandom), 2'($urandom), 1'($urandom), $urandom, 2'($urandom), "R3");

    check(holdErr == 0, "R9", "fields stable while waiting", 32'(holdErr), 32'd0);
    check(waitsSeen > 0, "R9", "waits exercised", 32'(waitsSeen), 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule